// File: doc/BRIEF.md
# Programmable XNOR-Feedback Shift Register

This block is an N-stage pseudo-random sequence generator with external feedback. Stages are numbered 1 to N in the direction of shifting. On each enabled clock every stage takes the value of the stage before it. Stage 1 takes the inverted parity of the stages chosen by a connection vector. That vector is an ordinary input, so the polynomial can change while running. The last stage is always part of the feedback, whatever is applied on its connection bit.

Because the feedback is inverted, the all-zero state is an ordinary member of the sequence. The state that can trap the register is all-ones instead. All-ones feeds back a 1 when the effective tap set, including the forced last stage, has an even number of members. A lock-up flag reports that situation while the register is held there.

A caller seeds the register with a load strobe, then steps it with an enable. The whole state is visible, and a serial bit is taken from the last stage. The parameter N may range from 2 to 32. Stage j lives in bit j-1 of every N-bit vector.

Top module: `xnor_lfsr`

## Requirements
- R1: A synchronous reset clears all N stages to zero on the next clock edge.
- R2: When `load` is high, the next state equals `seed` whatever `step_en` is. Load has priority over stepping.
- R3: With `load` and `step_en` both low, the state is unchanged.
- R4: On a step, bit j of the state takes the previous bit j-1, for j = 1 to N-1.
- R5: On a step, bit 0 (stage 1) becomes the complement of the XOR of every state bit whose `taps` bit is 1.
- R6: Bit N-1 of `taps` is treated as 1 whatever value it has. With N=5, taps=0 and state 5'h10, a step gives 5'h00.
- R7: `serial_o` always equals state bit N-1, the last stage.
- R8: `stuck_o` is 1 exactly when the state is all-ones and the effective tap set (`taps` with bit N-1 forced) has even weight. While it is 1, stepping leaves the state unchanged. With an odd-weight tap set, all-ones steps to all-ones with bit 0 cleared.
- R9: With N=5, taps on stages 3 and 5, and seed 5'h10, the register passes 31 distinct states and returns to the seed on step 31. The serial output, starting at the load, reads 1,0,0,0,0,0,1,1,1,0,0,1.
- R10: The all-zero state is not a trap: one step from zero gives 1 in bit 0 and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the register by one stage |
| load | input | 1 | Replace the state with `seed` |
| seed | input | N | Value loaded by `load` |
| taps | input | N | Connection vector; bit j-1 selects stage j |
| state_o | output | N | Current state, stage j in bit j-1 |
| serial_o | output | 1 | Last stage |
| stuck_o | output | 1 | All-ones lock-up indication |

## Verification
The hardest condition to reach from the ports is the lock-up state. The sequence never enters it from a legal start, so the bench must put it there with a seed load. The bench then checks it under an even-weight tap set, where it must hold and flag. It also checks it under an odd-weight set, where it must escape. The forced last-stage tap is shown only by a tap vector with that bit cleared, so the full-period run is made with bit N-1 of `taps` at zero. Every seed and connection vector is swept at N=3 against a behavioural model.

// File: rtl/xnor_lfsr.sv
module xnor_lfsr #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         load,
  input  logic [N-1:0] seed,
  input  logic [N-1:0] taps,
  output logic [N-1:0] state_o,
  output logic         serial_o,
  output logic         stuck_o
);
  localparam logic [N-1:0] LAST_TAP = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] st;
  logic [N-1:0] eff_taps;
  logic         fb;

  assign eff_taps = taps | LAST_TAP;
  assign fb       = ~^(st & eff_taps);

  always_ff @(posedge clk) begin
    if (rst)          st <= '0;
    else if (load)    st <= seed;
    else if (step_en) st <= {st[N-2:0], fb};
  end

  assign state_o  = st;
  assign serial_o = st[N-1];
  assign stuck_o  = (&st) & ~(^eff_taps);
endmodule

// File: rtl/xnor_lfsr_chk.sv
module xnor_lfsr_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         step_en,
  input logic         load,
  input logic [N-1:0] seed,
  input logic [N-1:0] taps,
  input logic [N-1:0] state_o,
  input logic         serial_o,
  input logic         stuck_o
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> state_o == '0); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) load |=> state_o == $past(seed)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!load && !step_en) |=> $stable(state_o)); // R3
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (rst) (!load && step_en) |=> state_o[N-1:1] == $past(state_o[N-2:0])); // R4
  AST_SERIAL_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (!load && step_en) |=> serial_o == $past(state_o[N-2])); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) (stuck_o && step_en && !load && $stable(taps)) |=> $stable(state_o) && (&state_o)); // R8
endmodule

bind xnor_lfsr xnor_lfsr_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .step_en(step_en), .load(load), .seed(seed),
  .taps(taps), .state_o(state_o), .serial_o(serial_o), .stuck_o(stuck_o)
);

// File: tb/xnor_lfsr_tb_top.sv
module xnor_lfsr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst = 1'b1;
  logic       en5 = 1'b0, ld5 = 1'b0;
  logic [4:0] seed5 = '0, taps5 = '0, st5;
  logic       ser5, stk5;
  logic       en3 = 1'b0, ld3 = 1'b0;
  logic [2:0] seed3 = '0, taps3 = '0, st3;
  logic       ser3, stk3;

  int errors = 0;
  int checks = 0;
  logic [31:0] m5 = '0, m3 = '0;

  xnor_lfsr #(.N(5)) dut_i (
    .clk(clk), .rst(rst), .step_en(en5), .load(ld5), .seed(seed5), .taps(taps5),
    .state_o(st5), .serial_o(ser5), .stuck_o(stk5));

  xnor_lfsr #(.N(3)) dut3_i (
    .clk(clk), .rst(rst), .step_en(en3), .load(ld3), .seed(seed3), .taps(taps3),
    .state_o(st3), .serial_o(ser3), .stuck_o(stk3));

  function automatic logic [31:0] ref_next(int n, logic [31:0] s, logic [31:0] t);
    logic par = 1'b0;
    logic [31:0] r;
    for (int j = 0; j < n; j++)
      if (t[j] || j == n-1) par = par ^ s[j];
    r = (s << 1) | {31'd0, ~par};
    for (int j = n; j < 32; j++) r[j] = 1'b0;
    return r;
  endfunction

  function automatic logic ref_stuck(int n, logic [31:0] s, logic [31:0] t);
    int w = 0;
    logic ones = 1'b1;
    for (int j = 0; j < n; j++) begin
      if (t[j] || j == n-1) w++;
      if (!s[j]) ones = 1'b0;
    end
    return ones && (w % 2 == 0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk);
    if (rst) begin m5 = '0; m3 = '0; end
    else begin
      if (ld5) m5 = {27'd0, seed5}; else if (en5) m5 = ref_next(5, m5, {27'd0, taps5});
      if (ld3) m3 = {29'd0, seed3}; else if (en3) m3 = ref_next(3, m3, {29'd0, taps3});
    end
    @(negedge clk);
    check({req, " R4 R5 state5"}, {27'd0, st5}, m5);
    check({req, " R7 serial5"}, {31'd0, ser5}, {31'd0, m5[4]});
    check({req, " R8 stuck5"}, {31'd0, stk5}, {31'd0, ref_stuck(5, m5, {27'd0, taps5})});
    check({req, " R4 R5 state3"}, {29'd0, st3}, m3);
    check({req, " R7 serial3"}, {31'd0, ser3}, {31'd0, m3[2]});
    check({req, " R8 stuck3"}, {31'd0, stk3}, {31'd0, ref_stuck(3, m3, {29'd0, taps3})});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seen;
    int first_ret, distinct;
    logic exp_ser [12] = '{1,0,0,0,0,0,1,1,1,0,0,1};

    @(negedge clk);
    tick("R1");
    tick("R1");
    check("R1 reset state", {27'd0, st5}, 32'd0);
    rst = 1'b0;

    ld5 = 1'b1; seed5 = 5'h16; tick("R2");
    check("R2 load", {27'd0, st5}, 32'h16);
    ld5 = 1'b0; tick("R3");
    check("R3 idle hold", {27'd0, st5}, 32'h16);
    ld5 = 1'b1; en5 = 1'b1; seed5 = 5'h09; tick("R2");
    check("R2 load over step", {27'd0, st5}, 32'h09);

    seed5 = 5'h00; en5 = 1'b0; tick("R10");
    ld5 = 1'b0; en5 = 1'b1; tick("R10");
    check("R10 zero escapes", {27'd0, st5}, 32'h01);

    en5 = 1'b0; ld5 = 1'b1; seed5 = 5'h10; taps5 = 5'b00000; tick("R6");
    ld5 = 1'b0; en5 = 1'b1; tick("R6");
    check("R6 forced last tap", {27'd0, st5}, 32'h00);

    en5 = 1'b0; ld5 = 1'b1; seed5 = 5'h10; taps5 = 5'b00100; tick("R9");
    ld5 = 1'b0; en5 = 1'b1;
    check("R7 R9 serial 0", {31'd0, ser5}, {31'd0, exp_ser[0]});
    seen = 32'd1 << 16; first_ret = 0; distinct = 1;
    for (int k = 1; k <= 31; k++) begin
      tick("R9");
      if (k < 12) check("R7 R9 serial seq", {31'd0, ser5}, {31'd0, exp_ser[k]});
      if (st5 == 5'h10 && first_ret == 0) first_ret = k;
      if (!seen[st5]) distinct++;
      seen[st5] = 1'b1;
    end
    check("R9 return step", first_ret, 31);
    check("R9 distinct states", distinct, 31);

    en5 = 1'b0; ld5 = 1'b1; seed5 = 5'h1F; taps5 = 5'b10100; tick("R8");
    check("R8 flag on even taps", {31'd0, stk5}, 32'd1);
    ld5 = 1'b0; en5 = 1'b1;
    repeat (3) tick("R8");
    check("R8 held in lock", {27'd0, st5}, 32'h1F);
    en5 = 1'b0; taps5 = 5'b00011; #1;
    check("R8 flag off odd taps", {31'd0, stk5}, 32'd0);
    en5 = 1'b1; tick("R8");
    check("R8 odd taps escape", {27'd0, st5}, 32'h1E);
    en5 = 1'b0;

    for (int t = 0; t < 8; t++) begin
      for (int s = 0; s < 8; s++) begin
        ld3 = 1'b1; en3 = 1'b1; seed3 = 3'(s); taps3 = 3'(t); tick("R2");
        check("R2 load n3", {29'd0, st3}, s);
        ld3 = 1'b0; tick("R5");
        check("R5 n3 sweep", {29'd0, st3}, ref_next(3, s, t));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule